// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Requester

This block lets a peripheral with two interrupt sources present requests on a shared request bus. The bus has eight lines and carries thirty-two priority levels. A two-bit slot code from the bus says which group of eight levels the lines stand for in the current cycle. Each source has a five-bit request level that software programs. The upper two bits of that level pick the slot and the lower three bits pick the line within it. A pending source drives its line only in the cycles whose slot code matches its level's group.

Each source has a sticky pending flag. An event pulse sets the flag and only an explicit clear resets it. The request therefore comes back in every matching slot until the flag is cleared. Software reaches the level registers through a simple request/response register port. That port checks privilege: the level registers accept only supervisor accesses. A user-mode access to them, or any access to an unmapped offset, is answered with a bus error.

Top module: `tmx_irq_requester`

## Requirements
- R1: After reset both level fields are 0, both pending flags are clear, `irq_lines` is all zero, and no register response is active.
- R2: Slot code s stands for levels 8s to 8s+7. A pending source with level L asserts line L[2:0] only while `slot_sel` equals L[4:3]. In every other slot it asserts nothing.
- R3: `irq_lines` is registered. It shows the line requests formed from `slot_sel`, the pending flags and the levels as they were at the previous rising clock edge.
- R4: A one-cycle pulse on `src_event[i]` sets pending flag i. The flag stays set through any number of slot cycles until `src_clear[i]` is high at an edge. When event and clear come together, the flag ends up set.
- R5: When both sources are pending in the same slot, their line requests are ORed together. Two sources with the same level produce a single line.
- R6: Offset 0 holds the level of source 0 (asynchronous serial) and offset 1 holds the level of source 1 (queued SPI), each in bits [4:0]. Higher write bits are dropped and read back as 0. These offsets accept supervisor accesses only.
- R7: Offset 2 is a pending view, with bit 0 for source 0 and bit 1 for source 1. It is acknowledged in both supervisor and user mode. Writes to it have no effect.
- R8: A user-mode access to offset 0 or 1 gets a bus error and does not change the level.
- R9: An access to any offset above 2 gets a bus error.
- R10: Each access receives exactly one response, `reg_ack` or `reg_berr`, in the cycle after `reg_req`. `reg_rdata` carries the read data with a read acknowledge and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_sel | input | 2 | Slot code naming the level group now on the lines |
| src_event | input | 2 | Event pulses that set the pending flags |
| src_clear | input | 2 | Clear strobes for the pending flags |
| reg_req | input | 1 | Register access request, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_super | input | 1 | 1 = supervisor mode access |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_ack | output | 1 | Access acknowledged |
| reg_berr | output | 1 | Access refused with a bus error |
| reg_rdata | output | 16 | Read data |
| irq_lines | output | 8 | Shared request lines for the current slot |

## Verification
The bench builds the block with its default parameters: eight lines, four slots, two sources and a four-bit offset. With these values the bench can sweep every one of the 32 levels through all four slot codes. The same values leave offsets 3 to 15 unmapped, so the bus-error path can be exercised. A table of two-source cases covers shared slots, shared levels and single-source pending. Directed cases cover the one-cycle output delay, event/clear collisions and privilege refusals.

// File: rtl/tmx_irq_pkg.sv
package tmx_irq_pkg;

    // Registered response of the configuration port
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_BERR = 2'd2
    } rsp_e;

    // Decoded class of a register offset
    typedef enum logic [1:0] {
        ACC_UNMAPPED = 2'd0,
        ACC_PRIV     = 2'd1,
        ACC_OPEN     = 2'd2
    } acc_e;

    // Offset classification: level registers below src_cnt, pending view at src_cnt
    function automatic acc_e classify(input int unsigned addr, input int unsigned src_cnt);
        if (addr < src_cnt)
            return ACC_PRIV;
        else if (addr == src_cnt)
            return ACC_OPEN;
        else
            return ACC_UNMAPPED;
    endfunction

endpackage

// File: rtl/tmx_irq_cfg_regs.sv
module tmx_irq_cfg_regs
    import tmx_irq_pkg::*;
#(
    parameter int SRC_CNT = 2,
    parameter int LVL_W   = 5,
    parameter int ADDR_W  = 4,
    parameter int REG_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_req,
    input  logic                          reg_wr,
    input  logic                          reg_super,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    input  logic [SRC_CNT-1:0]            pend_view,
    output logic [SRC_CNT-1:0][LVL_W-1:0] levels,
    output logic                          reg_ack,
    output logic                          reg_berr,
    output logic [REG_W-1:0]              reg_rdata
);

    acc_e             acc_kind;
    logic             refuse;
    logic [REG_W-1:0] rd_mux;
    rsp_e             rsp_q;
    logic [REG_W-1:0] rdata_q;

    always_comb begin
        acc_kind = classify(int'(reg_addr), SRC_CNT);
        refuse   = (acc_kind == ACC_UNMAPPED) || (acc_kind == ACC_PRIV && !reg_super);
    end

    // One level register per source
    for (genvar i = 0; i < SRC_CNT; i++) begin : g_lvl
        logic wr_hit;
        assign wr_hit = reg_req && reg_wr && reg_super && (reg_addr == ADDR_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                levels[i] <= '0;
            else if (wr_hit)
                levels[i] <= reg_wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < SRC_CNT; i++) begin
            if (reg_addr == ADDR_W'(i))
                rd_mux = REG_W'(levels[i]);
        end
        if (acc_kind == ACC_OPEN)
            rd_mux = REG_W'(pend_view);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q   <= RSP_NONE;
            rdata_q <= '0;
        end else if (!reg_req) begin
            rsp_q   <= RSP_NONE;
            rdata_q <= '0;
        end else if (refuse) begin
            rsp_q   <= RSP_BERR;
            rdata_q <= '0;
        end else begin
            rsp_q   <= RSP_ACK;
            rdata_q <= reg_wr ? '0 : rd_mux;
        end
    end

    assign reg_ack   = (rsp_q == RSP_ACK);
    assign reg_berr  = (rsp_q == RSP_BERR);
    assign reg_rdata = rdata_q;

endmodule

// File: rtl/tmx_irq_pending.sv
module tmx_irq_pending #(
    parameter int SRC_CNT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_CNT-1:0] src_event,
    input  logic [SRC_CNT-1:0] src_clear,
    output logic [SRC_CNT-1:0] pend_q
);

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (src_event[i])
                pend_q[i] <= 1'b1;
            else if (src_clear[i])
                pend_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/tmx_irq_line_encoder.sv
module tmx_irq_line_encoder #(
    parameter int SRC_CNT  = 2,
    parameter int LINE_CNT = 8,
    parameter int SLOT_CNT = 4,
    localparam int LINE_IDX_W = $clog2(LINE_CNT),
    localparam int SLOT_W     = $clog2(SLOT_CNT),
    localparam int LVL_W      = LINE_IDX_W + SLOT_W
) (
    input  logic [SLOT_W-1:0]             slot_sel,
    input  logic [SRC_CNT-1:0]            pend,
    input  logic [SRC_CNT-1:0][LVL_W-1:0] levels,
    output logic [LINE_CNT-1:0]           line_req
);

    logic [SRC_CNT-1:0][LINE_CNT-1:0] per_src;

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_src
        logic in_slot;
        assign in_slot    = pend[i] && (levels[i][LVL_W-1 -: SLOT_W] == slot_sel);
        assign per_src[i] = in_slot ? (LINE_CNT'(1) << levels[i][LINE_IDX_W-1:0]) : '0;
    end

    always_comb begin
        line_req = '0;
        for (int i = 0; i < SRC_CNT; i++)
            line_req = line_req | per_src[i];
    end

endmodule

// File: rtl/tmx_irq_requester.sv
module tmx_irq_requester #(
    parameter int LINE_CNT = 8,
    parameter int SLOT_CNT = 4,
    parameter int SRC_CNT  = 2,
    parameter int ADDR_W   = 4,
    parameter int REG_W    = 16,
    localparam int LINE_IDX_W = $clog2(LINE_CNT),
    localparam int SLOT_W     = $clog2(SLOT_CNT),
    localparam int LVL_W      = LINE_IDX_W + SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SLOT_W-1:0]   slot_sel,
    input  logic [SRC_CNT-1:0]  src_event,
    input  logic [SRC_CNT-1:0]  src_clear,
    input  logic                reg_req,
    input  logic                reg_wr,
    input  logic                reg_super,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic                reg_ack,
    output logic                reg_berr,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [LINE_CNT-1:0] irq_lines
);

    logic [SRC_CNT-1:0]            pend_q;
    logic [SRC_CNT-1:0][LVL_W-1:0] levels;
    logic [LINE_CNT-1:0]           line_req;

    tmx_irq_pending #(.SRC_CNT(SRC_CNT)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .src_event (src_event),
        .src_clear (src_clear),
        .pend_q    (pend_q)
    );

    tmx_irq_cfg_regs #(
        .SRC_CNT (SRC_CNT),
        .LVL_W   (LVL_W),
        .ADDR_W  (ADDR_W),
        .REG_W   (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_super (reg_super),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_view (pend_q),
        .levels    (levels),
        .reg_ack   (reg_ack),
        .reg_berr  (reg_berr),
        .reg_rdata (reg_rdata)
    );

    tmx_irq_line_encoder #(
        .SRC_CNT  (SRC_CNT),
        .LINE_CNT (LINE_CNT),
        .SLOT_CNT (SLOT_CNT)
    ) u_enc (
        .slot_sel (slot_sel),
        .pend     (pend_q),
        .levels   (levels),
        .line_req (line_req)
    );

    // Output register toward the shared bus
    always_ff @(posedge clk) begin
        if (rst)
            irq_lines <= '0;
        else
            irq_lines <= line_req;
    end

endmodule

// File: rtl/tmx_irq_requester_chk.sv
module tmx_irq_requester_chk #(
    parameter int LINE_CNT = 8,
    parameter int SRC_CNT  = 2,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [SRC_CNT-1:0]  src_event,
    input logic [SRC_CNT-1:0]  src_clear,
    input logic [SRC_CNT-1:0]  pend_q,
    input logic                reg_req,
    input logic                reg_super,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_ack,
    input logic                reg_berr,
    input logic [LINE_CNT-1:0] irq_lines
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_lines == '0 && !reg_ack && !reg_berr));

    // R10
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_ack && reg_berr));

    // R10
    one_resp_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> (reg_ack || reg_berr));

    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_req |=> (!reg_ack && !reg_berr));

    // R8
    user_priv_berr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_super && reg_addr < ADDR_W'(SRC_CNT)) |=> reg_berr);

    // R9
    unmapped_berr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_addr > ADDR_W'(SRC_CNT)) |=> reg_berr);

    // R4
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (src_clear == '1 && src_event == '0) |-> ##2 (irq_lines == '0));

    // R3
    lines_need_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) |-> ($past(pend_q) != '0));

    // R5
    line_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_lines) <= SRC_CNT);

endmodule

bind tmx_irq_requester tmx_irq_requester_chk #(
    .LINE_CNT (LINE_CNT),
    .SRC_CNT  (SRC_CNT),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_event (src_event),
    .src_clear (src_clear),
    .pend_q    (pend_q),
    .reg_req   (reg_req),
    .reg_super (reg_super),
    .reg_addr  (reg_addr),
    .reg_ack   (reg_ack),
    .reg_berr  (reg_berr),
    .irq_lines (irq_lines)
);

// File: tb/tb_tmx_irq_requester.sv
`timescale 1ns/1ps
module tb_tmx_irq_requester;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  slot_sel;
    logic [1:0]  src_event;
    logic [1:0]  src_clear;
    logic        reg_req;
    logic        reg_wr;
    logic        reg_super;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_ack;
    logic        reg_berr;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_lines;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmx_irq_requester dut (
        .clk       (clk),
        .rst       (rst),
        .slot_sel  (slot_sel),
        .src_event (src_event),
        .src_clear (src_clear),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_super (reg_super),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_berr  (reg_berr),
        .reg_rdata (reg_rdata),
        .irq_lines (irq_lines)
    );

    typedef struct packed {
        logic [4:0] lvl_a;
        logic [4:0] lvl_b;
        logic [1:0] pmask;
        logic [1:0] slot;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{5'd5,  5'd12, 2'b11, 2'd0, 8'h20},
        '{5'd5,  5'd12, 2'b11, 2'd1, 8'h10},
        '{5'd5,  5'd12, 2'b11, 2'd2, 8'h00},
        '{5'd3,  5'd6,  2'b11, 2'd0, 8'h48},
        '{5'd9,  5'd9,  2'b11, 2'd1, 8'h02},
        '{5'd31, 5'd24, 2'b11, 2'd3, 8'h81},
        '{5'd31, 5'd24, 2'b01, 2'd3, 8'h80},
        '{5'd31, 5'd24, 2'b10, 2'd3, 8'h01},
        '{5'd17, 5'd20, 2'b00, 2'd2, 8'h00},
        '{5'd17, 5'd20, 2'b11, 2'd2, 8'h12}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic sup, input logic [3:0] addr,
                       input logic [15:0] wd, output logic ack, output logic berr,
                       output logic [15:0] rd);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = wr; reg_super = sup; reg_addr = addr; reg_wdata = wd;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
        ack = reg_ack; berr = reg_berr; rd = reg_rdata;
    endtask

    task automatic pulse(input logic [1:0] ev, input logic [1:0] cl);
        @(negedge clk);
        src_event = ev; src_clear = cl;
        @(negedge clk);
        src_event = 2'b00; src_clear = 2'b00;
    endtask

    task automatic slot_sample(input logic [1:0] s, output logic [7:0] lines);
        @(negedge clk);
        slot_sel = s;
        @(negedge clk);
        lines = irq_lines;
    endtask

    function automatic logic [7:0] line_of(input logic [4:0] lvl, input logic [1:0] s);
        return (lvl[4:3] == s) ? (8'h01 << lvl[2:0]) : 8'h00;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic ack, berr;
        logic [15:0] rd;
        logic [7:0] lines;

        rst = 1'b1; slot_sel = 2'd0; src_event = 2'b00; src_clear = 2'b00;
        reg_req = 1'b0; reg_wr = 1'b0; reg_super = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_lines", 32'(irq_lines), 32'h0);
        check("R1 no ack", 32'(reg_ack), 32'h0);
        bus(1'b0, 1'b1, 4'd0, 16'h0, ack, berr, rd);
        check("R1 level0", 32'(rd), 32'h0);
        bus(1'b0, 1'b1, 4'd1, 16'h0, ack, berr, rd);
        check("R1 level1", 32'(rd), 32'h0);
        bus(1'b0, 1'b0, 4'd2, 16'h0, ack, berr, rd);
        check("R1 pending", 32'(rd), 32'h0);

        // R2 sweep of all 32 levels across all four slots (source 0)
        for (int lvl = 0; lvl < 32; lvl++) begin
            pulse(2'b00, 2'b11);
            bus(1'b1, 1'b1, 4'd0, 16'(lvl), ack, berr, rd);
            pulse(2'b01, 2'b00);
            for (int s = 0; s < 4; s++) begin
                slot_sample(2'(s), lines);
                check($sformatf("R2 lvl=%0d slot=%0d", lvl, s), 32'(lines),
                      32'(line_of(5'(lvl), 2'(s))));
            end
        end

        // R5 two-source table
        for (int v = 0; v < NVEC; v++) begin
            pulse(2'b00, 2'b11);
            bus(1'b1, 1'b1, 4'd0, 16'(VECS[v].lvl_a), ack, berr, rd);
            bus(1'b1, 1'b1, 4'd1, 16'(VECS[v].lvl_b), ack, berr, rd);
            pulse(VECS[v].pmask, 2'b00);
            slot_sample(VECS[v].slot, lines);
            check($sformatf("R5 vec=%0d", v), 32'(lines), 32'(VECS[v].exp));
        end

        // R3 one-cycle latency: source 0 level 2 pending, slot 1 then slot 0
        pulse(2'b00, 2'b11);
        bus(1'b1, 1'b1, 4'd0, 16'd2, ack, berr, rd);
        pulse(2'b01, 2'b00);
        slot_sample(2'd1, lines);
        check("R3 other slot", 32'(lines), 32'h0);
        @(negedge clk);
        slot_sel = 2'd0;
        #1;
        check("R3 before edge", 32'(irq_lines), 32'h0);
        @(negedge clk);
        check("R3 after edge", 32'(irq_lines), 32'h04);

        // R4 sticky across slots, source 1 level 7
        pulse(2'b00, 2'b11);
        bus(1'b1, 1'b1, 4'd1, 16'd7, ack, berr, rd);
        pulse(2'b10, 2'b00);
        for (int k = 0; k < 3; k++) begin
            slot_sample(2'd3, lines);
            check("R4 sticky off-slot", 32'(lines), 32'h0);
            slot_sample(2'd0, lines);
            check("R4 sticky on-slot", 32'(lines), 32'h80);
        end
        pulse(2'b00, 2'b10);
        slot_sample(2'd0, lines);
        check("R4 cleared", 32'(lines), 32'h0);
        // event and clear together: flag set
        pulse(2'b10, 2'b10);
        bus(1'b0, 1'b0, 4'd2, 16'h0, ack, berr, rd);
        check("R4 event wins", 32'(rd), 32'h2);

        // R7 pending view writes ignored, user read acked
        bus(1'b1, 1'b0, 4'd2, 16'h0000, ack, berr, rd);
        check("R7 write ack", 32'(ack), 32'h1);
        bus(1'b0, 1'b0, 4'd2, 16'h0, ack, berr, rd);
        check("R7 write ignored", 32'(rd), 32'h2);
        check("R7 read ack", 32'(ack), 32'h1);

        // R6 upper bits dropped
        bus(1'b1, 1'b1, 4'd0, 16'hFFE3, ack, berr, rd);
        check("R6 write ack", 32'(ack), 32'h1);
        bus(1'b0, 1'b1, 4'd0, 16'h0, ack, berr, rd);
        check("R6 readback", 32'(rd), 32'h03);

        // R8 user write refused, level kept
        bus(1'b1, 1'b0, 4'd0, 16'd20, ack, berr, rd);
        check("R8 berr", 32'(berr), 32'h1);
        check("R8 no ack", 32'(ack), 32'h0);
        bus(1'b0, 1'b0, 4'd1, 16'h0, ack, berr, rd);
        check("R8 user read berr", 32'(berr), 32'h1);
        bus(1'b0, 1'b1, 4'd0, 16'h0, ack, berr, rd);
        check("R8 level kept", 32'(rd), 32'h03);

        // R9 unmapped offsets
        bus(1'b0, 1'b1, 4'd3, 16'h0, ack, berr, rd);
        check("R9 offset3 berr", 32'(berr), 32'h1);
        bus(1'b1, 1'b1, 4'd15, 16'h1, ack, berr, rd);
        check("R9 offset15 berr", 32'(berr), 32'h1);

        // R10 rdata zero on error and on write ack, no response when idle
        check("R10 rdata on berr", 32'(rd), 32'h0);
        bus(1'b1, 1'b1, 4'd1, 16'd9, ack, berr, rd);
        check("R10 rdata on write", 32'(rd), 32'h0);
        @(negedge clk);
        check("R10 idle", 32'({reg_ack, reg_berr}), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule